// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only slave on a three-wire serial bus: a serial clock, an active-low load strobe and a data line. All three lines are oversampled by the block's own system clock through two-flop synchronizers, and edge detectors turn them into shift, frame-start and commit pulses. Each frame opens with an 8-bit address, most significant bit first.

An address below `CTRL_DEPTH` is a control address. It is followed by 24 data bits, and one 24-bit control register is written per frame. Three addresses open a counted burst instead. 0x14 selects the 17-word system bank, 0x15 mode bank A and 0x16 mode bank B. After the address comes a 24-bit word count, then 32-bit words that fill the bank from entry 0 upward. Every received value first lands in shadow storage. It reaches the live registers only when the strobe returns high. Bit 0 of control register 0x0A selects which mode bank drives the mode outputs.

The frame engine has six named states:
- S_IDLE waits for the strobe to fall and moves to S_ADDR.
- S_ADDR receives the address. After the eighth bit it moves to S_COUNT for a bank address, to S_CTRL for an implemented control address, and to S_DRAIN for anything else.
- S_CTRL receives the 24 control data bits and then moves to S_DRAIN.
- S_COUNT receives the 24-bit count and then moves to S_DATA.
- S_DATA receives words. After the word that reaches the burst target it moves to S_DRAIN.
- S_DRAIN ignores all further bits.

From any state, a rising strobe returns the engine to S_IDLE.

Top module: `serial_cfg_port`

## Requirements
- R1: The data line is sampled on rising serial-clock edges only while the strobe is low. Serial-clock pulses while the strobe is high shift nothing and do not disturb the alignment of the next frame.
- R2: A frame with address a < 16 followed by 24 data bits (D23 first) writes control register a. Register a appears on `ctrl_regs_o[24*a +: 24]`.
- R3: Frames to addresses 0x10–0x13 and 0x17–0xFF change no output.
- R4: One control register is written per strobe-low period. Bits sent after the 32nd are ignored.
- R5: While the strobe is low, no output changes. New values appear within 4 system clocks after the strobe rises.
- R6: A frame sends address 0x14 (system bank, 17 entries), 0x15 (mode bank A, 8 entries) or 0x16 (mode bank B, 8 entries), then a 24-bit count N, then N 32-bit words MSB first. Word k lands in entry k. System entry i is `sys_regs_o[32*i +: 32]`.
- R7: A count of zero writes the whole selected bank.
- R8: A count larger than the bank depth writes entries up to the last one. Further bits are ignored.
- R9: If the strobe rises in the middle of a word, that partial word is discarded and the complete words before it are committed.
- R10: Bit 0 of control register 0x0A selects the mode bank. A value of 0 puts bank A on `mode_regs_o` (entry i at bits 32*i +: 32), and a value of 1 puts bank B there. The bit also appears on `mode_sel_o`.
- R11: After reset, every register and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bus clock |
| ser_load_n | input | 1 | Active-low load strobe that frames a transfer |
| ser_data | input | 1 | Serial data, MSB first |
| ctrl_regs_o | output | CTRL_DEPTH*24 | Live control registers, concatenated |
| sys_regs_o | output | 17*32 | Live system bank, concatenated |
| mode_regs_o | output | 8*32 | Mode bank currently selected |
| mode_sel_o | output | 1 | Mode bank select (1 selects bank B) |

## Verification
A bit counter that drifts by one shows up right away: the next committed register holds a value shifted by one bit, and it is visible three clocks after the strobe rises. A shadow mask that is not cleared, or a burst target that is computed wrongly, changes bank entries beyond the last word that should land. An engine that leaves S_DRAIN too early makes a later register change when it should not. Every frame is compared against the full expected register image. The outputs are also checked while the strobe is still low, so any early update is caught within the same frame.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    localparam int ADDR_W     = 8;
    localparam int CTRL_W     = 24;
    localparam int CNT_W      = 24;
    localparam int WORD_W     = 32;
    localparam int SYS_DEPTH  = 17;
    localparam int MODE_DEPTH = 8;
    localparam int WIDX_W     = $clog2(SYS_DEPTH + 1);
    localparam int BIT_W      = $clog2(WORD_W);

    localparam logic [ADDR_W-1:0] SYS_BANK_ADDR  = 8'h14;
    localparam logic [ADDR_W-1:0] MODEA_ADDR     = 8'h15;
    localparam logic [ADDR_W-1:0] MODEB_ADDR     = 8'h16;
    localparam logic [ADDR_W-1:0] MODE_SEL_ADDR  = 8'h0A;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_CTRL, S_COUNT, S_DATA, S_DRAIN
    } frame_state_t;

    typedef enum logic [1:0] {
        BK_NONE, BK_SYS, BK_MA, BK_MB
    } bank_sel_t;
endpackage

// File: rtl/scfg_sync_edge.sv
module scfg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic load_n_i,
    input  logic data_i,
    output logic shift_o,
    output logic start_o,
    output logic commit_o,
    output logic bit_o
);
    localparam logic [2:0] REST_LVL = 3'b010;  // {data, load_n, sclk}

    logic [2:0] chain [STAGES];
    logic       prev_sclk, prev_load;
    logic       sclk_s, load_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= REST_LVL;
            prev_sclk <= 1'b0;
            prev_load <= 1'b1;
        end else begin
            chain[0] <= {data_i, load_n_i, sclk_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev_sclk <= sclk_s;
            prev_load <= load_s;
        end
    end

    assign sclk_s   = chain[STAGES-1][0];
    assign load_s   = chain[STAGES-1][1];
    assign bit_o    = chain[STAGES-1][2];
    assign shift_o  = sclk_s & ~prev_sclk & ~load_s;
    assign start_o  = ~load_s & prev_load;
    assign commit_o = load_s & ~prev_load;
endmodule

// File: rtl/scfg_frame_fsm.sv
module scfg_frame_fsm
    import scfg_pkg::*;
#(
    parameter int CTRL_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic                start_i,
    input  logic                commit_i,
    input  logic                bit_i,
    output frame_state_t        state_o,
    output bank_sel_t           bank_o,
    output logic                ctrl_we_o,
    output logic [ADDR_W-1:0]   ctrl_addr_o,
    output logic [CTRL_W-1:0]   ctrl_data_o,
    output logic                word_we_o,
    output logic [WIDX_W-1:0]   word_idx_o,
    output logic [WORD_W-1:0]   word_data_o,
    output logic [WIDX_W-1:0]   fill_o,
    output logic [WIDX_W-1:0]   target_o
);
    localparam logic [ADDR_W-1:0] CTRL_LIMIT = ADDR_W'(CTRL_DEPTH);

    frame_state_t        state, nstate;
    logic [BIT_W-1:0]    bitcnt;
    logic [WORD_W-2:0]   sh;
    logic [WORD_W-1:0]   shv;
    logic [ADDR_W-1:0]   addr_now;
    logic [CNT_W-1:0]    cnt_now;
    bank_sel_t           bank_now;
    logic [WIDX_W-1:0]   depth_now;

    assign shv      = {sh, bit_i};
    assign addr_now = shv[ADDR_W-1:0];
    assign cnt_now  = shv[CNT_W-1:0];
    assign state_o  = state;

    always_comb begin
        unique case (addr_now)
            SYS_BANK_ADDR: bank_now = BK_SYS;
            MODEA_ADDR:    bank_now = BK_MA;
            MODEB_ADDR:    bank_now = BK_MB;
            default:       bank_now = BK_NONE;
        endcase
    end

    assign depth_now = (bank_o == BK_SYS) ? WIDX_W'(SYS_DEPTH) : WIDX_W'(MODE_DEPTH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (start_i) nstate = S_ADDR;
            S_ADDR:  if (shift_i && bitcnt == BIT_W'(ADDR_W-1)) begin
                         if (bank_now != BK_NONE)       nstate = S_COUNT;
                         else if (addr_now < CTRL_LIMIT) nstate = S_CTRL;
                         else                            nstate = S_DRAIN;
                     end
            S_CTRL:  if (shift_i && bitcnt == BIT_W'(CTRL_W-1)) nstate = S_DRAIN;
            S_COUNT: if (shift_i && bitcnt == BIT_W'(CNT_W-1))  nstate = S_DATA;
            S_DATA:  if (shift_i && bitcnt == BIT_W'(WORD_W-1) &&
                         WIDX_W'(fill_o + 1'b1) == target_o)    nstate = S_DRAIN;
            S_DRAIN: nstate = S_DRAIN;
            default: nstate = S_IDLE;
        endcase
        if (commit_i) nstate = S_IDLE;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt      <= '0;
            sh          <= '0;
            bank_o      <= BK_NONE;
            ctrl_we_o   <= 1'b0;
            ctrl_addr_o <= '0;
            ctrl_data_o <= '0;
            word_we_o   <= 1'b0;
            word_idx_o  <= '0;
            word_data_o <= '0;
            fill_o      <= '0;
            target_o    <= '0;
        end else begin
            ctrl_we_o <= 1'b0;
            word_we_o <= 1'b0;
            if (start_i) begin
                bitcnt <= '0;
                fill_o <= '0;
            end else if (shift_i && state inside {S_ADDR, S_CTRL, S_COUNT, S_DATA}) begin
                sh     <= shv[WORD_W-2:0];
                bitcnt <= BIT_W'(bitcnt + 1'b1);
                unique case (state)
                    S_ADDR: if (bitcnt == BIT_W'(ADDR_W-1)) begin
                        bitcnt      <= '0;
                        ctrl_addr_o <= addr_now;
                        bank_o      <= bank_now;
                    end
                    S_CTRL: if (bitcnt == BIT_W'(CTRL_W-1)) begin
                        ctrl_we_o   <= 1'b1;
                        ctrl_data_o <= shv[CTRL_W-1:0];
                    end
                    S_COUNT: if (bitcnt == BIT_W'(CNT_W-1)) begin
                        bitcnt <= '0;
                        if (cnt_now == '0 || cnt_now > CNT_W'(depth_now))
                            target_o <= depth_now;
                        else
                            target_o <= cnt_now[WIDX_W-1:0];
                    end
                    S_DATA: if (bitcnt == BIT_W'(WORD_W-1)) begin
                        bitcnt      <= '0;
                        word_we_o   <= 1'b1;
                        word_idx_o  <= fill_o;
                        word_data_o <= shv;
                        fill_o      <= WIDX_W'(fill_o + 1'b1);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/scfg_regstore.sv
module scfg_regstore
    import scfg_pkg::*;
#(
    parameter int CTRL_DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic                           commit_i,
    input  bank_sel_t                      bank_i,
    input  logic                           ctrl_we_i,
    input  logic [ADDR_W-1:0]              ctrl_addr_i,
    input  logic [CTRL_W-1:0]              ctrl_data_i,
    input  logic                           word_we_i,
    input  logic [WIDX_W-1:0]              word_idx_i,
    input  logic [WORD_W-1:0]              word_data_i,
    output logic [CTRL_DEPTH*CTRL_W-1:0]   ctrl_flat_o,
    output logic [SYS_DEPTH*WORD_W-1:0]    sys_flat_o,
    output logic [MODE_DEPTH*WORD_W-1:0]   ma_flat_o,
    output logic [MODE_DEPTH*WORD_W-1:0]   mb_flat_o
);
    localparam int CIDX_W = $clog2(CTRL_DEPTH);

    logic [CTRL_W-1:0]  ctrl_q [CTRL_DEPTH];
    logic [WORD_W-1:0]  sys_q  [SYS_DEPTH];
    logic [WORD_W-1:0]  ma_q   [MODE_DEPTH];
    logic [WORD_W-1:0]  mb_q   [MODE_DEPTH];
    logic [WORD_W-1:0]  shadow [SYS_DEPTH];
    logic [SYS_DEPTH-1:0] mask;
    logic               pend_v;
    logic [CIDX_W-1:0]  pend_addr;
    logic [CTRL_W-1:0]  pend_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CTRL_DEPTH; i++) ctrl_q[i] <= '0;
            for (int i = 0; i < SYS_DEPTH; i++) begin
                sys_q[i]  <= '0;
                shadow[i] <= '0;
            end
            for (int i = 0; i < MODE_DEPTH; i++) begin
                ma_q[i] <= '0;
                mb_q[i] <= '0;
            end
            mask      <= '0;
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (commit_i) begin
            if (pend_v) ctrl_q[pend_addr] <= pend_data;
            for (int i = 0; i < SYS_DEPTH; i++)
                if (mask[i] && bank_i == BK_SYS) sys_q[i] <= shadow[i];
            for (int i = 0; i < MODE_DEPTH; i++) begin
                if (mask[i] && bank_i == BK_MA) ma_q[i] <= shadow[i];
                if (mask[i] && bank_i == BK_MB) mb_q[i] <= shadow[i];
            end
            mask   <= '0;
            pend_v <= 1'b0;
        end else begin
            if (start_i) begin
                mask   <= '0;
                pend_v <= 1'b0;
            end
            if (ctrl_we_i) begin
                pend_v    <= 1'b1;
                pend_addr <= ctrl_addr_i[CIDX_W-1:0];
                pend_data <= ctrl_data_i;
            end
            if (word_we_i) begin
                shadow[word_idx_i] <= word_data_i;
                mask[word_idx_i]   <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < CTRL_DEPTH; g++) begin : g_ctrl
        assign ctrl_flat_o[g*CTRL_W +: CTRL_W] = ctrl_q[g];
    end
    for (genvar g = 0; g < SYS_DEPTH; g++) begin : g_sys
        assign sys_flat_o[g*WORD_W +: WORD_W] = sys_q[g];
    end
    for (genvar g = 0; g < MODE_DEPTH; g++) begin : g_mode
        assign ma_flat_o[g*WORD_W +: WORD_W] = ma_q[g];
        assign mb_flat_o[g*WORD_W +: WORD_W] = mb_q[g];
    end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import scfg_pkg::*;
#(
    parameter int CTRL_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ser_clk,
    input  logic                                 ser_load_n,
    input  logic                                 ser_data,
    output logic [CTRL_DEPTH*CTRL_W-1:0]         ctrl_regs_o,
    output logic [SYS_DEPTH*WORD_W-1:0]          sys_regs_o,
    output logic [MODE_DEPTH*WORD_W-1:0]         mode_regs_o,
    output logic                                 mode_sel_o
);
    localparam int MSEL_BIT = int'(MODE_SEL_ADDR) * CTRL_W;

    logic                 shift_p, start_p, commit_p, bit_s;
    frame_state_t         st;
    bank_sel_t            bank;
    logic                 ctrl_we, word_we;
    logic [ADDR_W-1:0]    ctrl_addr;
    logic [CTRL_W-1:0]    ctrl_data;
    logic [WIDX_W-1:0]    word_idx, fill, target;
    logic [WORD_W-1:0]    word_data;
    logic [MODE_DEPTH*WORD_W-1:0] ma_flat, mb_flat;

    scfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(ser_clk), .load_n_i(ser_load_n), .data_i(ser_data),
        .shift_o(shift_p), .start_o(start_p), .commit_o(commit_p), .bit_o(bit_s)
    );

    scfg_frame_fsm #(.CTRL_DEPTH(CTRL_DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .shift_i(shift_p), .start_i(start_p), .commit_i(commit_p), .bit_i(bit_s),
        .state_o(st), .bank_o(bank),
        .ctrl_we_o(ctrl_we), .ctrl_addr_o(ctrl_addr), .ctrl_data_o(ctrl_data),
        .word_we_o(word_we), .word_idx_o(word_idx), .word_data_o(word_data),
        .fill_o(fill), .target_o(target)
    );

    scfg_regstore #(.CTRL_DEPTH(CTRL_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_p), .commit_i(commit_p), .bank_i(bank),
        .ctrl_we_i(ctrl_we), .ctrl_addr_i(ctrl_addr), .ctrl_data_i(ctrl_data),
        .word_we_i(word_we), .word_idx_i(word_idx), .word_data_i(word_data),
        .ctrl_flat_o(ctrl_regs_o), .sys_flat_o(sys_regs_o),
        .ma_flat_o(ma_flat), .mb_flat_o(mb_flat)
    );

    assign mode_sel_o  = ctrl_regs_o[MSEL_BIT];
    assign mode_regs_o = mode_sel_o ? mb_flat : ma_flat;
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker
    import scfg_pkg::*;
#(
    parameter int CTRL_DEPTH = 16
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               commit,
    input frame_state_t                       state,
    input logic [WIDX_W-1:0]                  fill,
    input logic [WIDX_W-1:0]                  target,
    input logic [CTRL_DEPTH*CTRL_W-1:0]       ctrl_o,
    input logic [SYS_DEPTH*WORD_W-1:0]        sys_o,
    input logic                               msel_o
);
    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctrl_o));

    assert_sys_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(sys_o));

    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(msel_o));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA) |-> (fill < target));

    assert_idle_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == S_IDLE));
endmodule

bind serial_cfg_port scfg_checker #(.CTRL_DEPTH(CTRL_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit_p), .state(st),
    .fill(fill), .target(target),
    .ctrl_o(ctrl_regs_o), .sys_o(sys_regs_o), .msel_o(mode_sel_o)
);

// File: tb/sim_serial_cfg_port.sv
module sim_serial_cfg_port;
    localparam int CLK_P = 10;
    localparam int HALF  = 4 * CLK_P;
    localparam int CD    = 16;
    localparam int WD    = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_load_n = 1'b1, ser_data = 1'b0;
    logic [CD*24-1:0] ctrl_regs_o;
    logic [17*32-1:0] sys_regs_o;
    logic [8*32-1:0]  mode_regs_o;
    logic             mode_sel_o;

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [23:0] e_ctrl [CD];
    logic [31:0] e_sys [17];
    logic [31:0] e_ma [8];
    logic [31:0] e_mb [8];

    always #(CLK_P/2) clk = ~clk;

    serial_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_load_n(ser_load_n),
        .ser_data(ser_data), .ctrl_regs_o(ctrl_regs_o), .sys_regs_o(sys_regs_o),
        .mode_regs_o(mode_regs_o), .mode_sel_o(mode_sel_o)
    );

    function automatic logic [31:0] wv(int b, int i, int s);
        return (32'h9E3779B9 * (i + 1)) ^ (b << 24) ^ (s * 32'h00010F03);
    endfunction

    task automatic cmp(string req, string what, logic [543:0] act, logic [543:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        logic [CD*24-1:0] ec;
        logic [17*32-1:0] es;
        logic [8*32-1:0]  em;
        logic             sel;
        sel = e_ctrl[10][0];
        for (int i = 0; i < CD; i++) ec[i*24 +: 24] = e_ctrl[i];
        for (int i = 0; i < 17; i++) es[i*32 +: 32] = e_sys[i];
        for (int i = 0; i < 8; i++)  em[i*32 +: 32] = sel ? e_mb[i] : e_ma[i];
        cmp(req, "ctrl", 544'(ctrl_regs_o), 544'(ec));
        cmp(req, "sys", 544'(sys_regs_o), 544'(es));
        cmp(req, "mode", 544'(mode_regs_o), 544'(em));
        cmp(req, "msel", 544'(mode_sel_o), 544'(sel));
    endtask

    task automatic sbit(logic b);
        ser_data = b;
        #(HALF) ser_clk = 1'b1;
        #(HALF) ser_clk = 1'b0;
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic open_frame();
        ser_load_n = 1'b0;
        #(HALF);
    endtask

    task automatic close_frame();
        #(HALF);
        check_all("R5");  // strobe still low: outputs hold old values
        ser_load_n = 1'b1;
        #(8 * CLK_P);
    endtask

    task automatic ctrl_frame(int a, logic [23:0] v, int extra, string req);
        open_frame();
        send_bits(32'(a), 8);
        send_bits(32'(v), 24);
        for (int k = 0; k < extra; k++) sbit(k[0]);
        close_frame();
        if (a < CD) e_ctrl[a] = v;
        check_all(req);
    endtask

    task automatic bank_frame(int a, int cnt, int full, int part, int seed, string req);
        int depth, tgt, k;
        depth = (a == 8'h14) ? 17 : 8;
        tgt = (cnt == 0 || cnt > depth) ? depth : cnt;
        k = (full < tgt) ? full : tgt;
        open_frame();
        send_bits(32'(a), 8);
        send_bits(32'(cnt), 24);
        for (int i = 0; i < full; i++) send_bits(wv(a, i, seed), 32);
        if (part > 0) send_bits(wv(a, full, seed) >> (32 - part), part);
        close_frame();
        for (int i = 0; i < k; i++) begin
            if (a == 8'h14)      e_sys[i] = wv(a, i, seed);
            else if (a == 8'h15) e_ma[i]  = wv(a, i, seed);
            else                 e_mb[i]  = wv(a, i, seed);
        end
        check_all(req);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < CD; i++) e_ctrl[i] = '0;
        for (int i = 0; i < 17; i++) e_sys[i] = '0;
        for (int i = 0; i < 8; i++) begin e_ma[i] = '0; e_mb[i] = '0; end
        #(5 * CLK_P) rst_n = 1'b1;
        #(4 * CLK_P);
        check_all("R11");

        // R2: every implemented control address
        for (int a = 0; a < CD; a++)
            ctrl_frame(a, 24'((a * 24'h010203) ^ 24'hA5C35A), 0, "R2");

        // R3: unimplemented addresses leave every output alone
        ctrl_frame(8'h10, 24'hFFFFFF, 0, "R3");
        ctrl_frame(8'h13, 24'h123456, 0, "R3");
        ctrl_frame(8'h17, 24'hABCDEF, 0, "R3");
        ctrl_frame(8'h80, 24'h0F0F0F, 0, "R3");
        ctrl_frame(8'hD6, 24'h777777, 0, "R3");
        ctrl_frame(8'hFF, 24'h5A5A5A, 0, "R3");

        // R4: trailing bits after the 32nd are ignored
        ctrl_frame(3, 24'h3C3C3C, 40, "R4");

        // R1: clocks with strobe high are not sampled
        for (int k = 0; k < 13; k++) sbit(1'b1);
        #(8 * CLK_P);
        check_all("R1");
        ctrl_frame(5, 24'h0B0B05, 0, "R1");

        // system bank
        bank_frame(8'h14, 0, 17, 0, 1, "R7");
        bank_frame(8'h14, 5, 5, 0, 2, "R6");
        bank_frame(8'h14, 20, 20, 0, 3, "R8");
        bank_frame(8'h14, 4, 2, 20, 4, "R9");
        bank_frame(8'h14, 3, 0, 31, 5, "R9");

        // mode banks
        bank_frame(8'h15, 0, 8, 0, 6, "R7");
        for (int n = 1; n <= 10; n++) bank_frame(8'h16, n, n, 0, 10 + n, "R6");
        bank_frame(8'h16, 24'hFFFFFF, 9, 0, 30, "R8");
        bank_frame(8'h15, 6, 3, 7, 31, "R9");

        // R10: bank select
        ctrl_frame(8'h0A, 24'h000001, 0, "R10");
        ctrl_frame(8'h0A, 24'hFFFFFE, 0, "R10");
        ctrl_frame(8'h0A, 24'h800003, 0, "R10");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule